// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Error Flags

This block is the receive half of an asynchronous serial port. A free-running oversampling enable from an external divider paces it, `OVERSAMPLE` pulses per bit. The serial input first passes through a two-flop synchronizer and a deglitch filter. A falling edge on the filtered line starts a frame, and the start bit is confirmed at its middle. The following bits are sampled one full bit period apart. A finished character goes into a single holding buffer together with a data-ready flag, an address flag and sticky error flags. All of these stay until the host pulses a read strobe.

Static control inputs set the frame shape: 7 or 8 data bits, optional parity of either sense, and one or two stop bits. They also pick how addresses are marked. In address-bit mode an extra bit follows the data and parity bits. In idle-line mode, the first character after a long mark is the address. A wake filter can restrict delivery to address characters. Characters that carry errors can be dropped or delivered with their flags set. A synchronous soft reset holds the receiver idle and clears every flag.

Top module: `mp_uart_rx`

## Requirements
- R1: Data bits are taken least significant first. With 8 data bits, a character received with a high stop bit lands in `rx_data` and raises `rx_ready`.
- R2: With `cfg_len8` = 0, the 7 received bits appear in `rx_data[6:0]` and `rx_data[7]` reads 0.
- R3: When `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_even` = 1 means the data bits plus the parity bit hold an even number of ones, and 0 means an odd number. A mismatch sets `err_parity`. When `cfg_par_en` = 0, no parity bit is expected and `err_parity` stays 0.
- R4: With `cfg_two_stop` = 0, a single stop bit follows the frame. With 1, two stop bits follow. `err_frame` sets if any stop bit is sampled low.
- R5: `err_break` sets when every sampled bit of the frame is 0: data, parity, address and first stop bit.
- R6: `err_overrun` sets when a character is placed in the buffer while `rx_ready` is still 1. The buffer then holds the newer character.
- R7: With `cfg_addr_bit_mode` = 1, one extra bit follows the data bits and the parity bit if present. A value of 1 sets `rx_is_addr` and a value of 0 clears it.
- R8: With `cfg_addr_bit_mode` = 0, a mark lasting more than 10 bit periods after a stop bit (or after reset) makes the next character an address (`rx_is_addr` = 1). Later characters without such a gap are data.
- R9: With `cfg_wake_filter` = 1, only address characters are delivered. Data characters leave the buffer and every flag untouched. With 0, every character is delivered.
- R10: With `cfg_keep_err` = 0, a character with a framing, parity or break error is discarded and changes no output. With 1, it is delivered with its flags set.
- R11: A one-cycle `rd_strobe` clears `rx_ready`, `rx_is_addr` and all error flags. `err_any` is the OR of the four error flags.
- R12: A low pulse on `rx_serial` shorter than `DEGLITCH_CYC` clocks starts nothing. A start bit found high at its midpoint returns the receiver to idle, and it delivers no character.
- R13: While `soft_rst` is 1, all flags read 0 and no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous hold-idle and flag clear |
| os_tick | input | 1 | Oversampling enable, OVERSAMPLE pulses per bit |
| rx_serial | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_addr_bit_mode | input | 1 | 1: address-bit marking, 0: idle-line marking |
| cfg_wake_filter | input | 1 | Deliver only address characters |
| cfg_keep_err | input | 1 | Deliver characters that carry errors |
| rd_strobe | input | 1 | Buffer read, clears flags |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | Character waiting |
| rx_is_addr | output | 1 | Waiting character is an address |
| err_frame | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Unread character overwritten |
| err_break | output | 1 | All-zero frame |
| err_any | output | 1 | OR of the four error flags |

## Verification
A line edge reaches the framer after the two-flop synchronizer and `DEGLITCH_CYC` filter clocks. The last stop bit is sampled half a bit period later, and the buffer and flags change on the clock after that. With the defaults of 2 clocks per tick and 16 ticks per bit, that lands about 24 clocks into the last stop bit. The bench therefore checks each frame's results only after it has driven the complete last stop bit, which is 32 clocks, and it samples on the falling clock edge. Read-strobe effects are due one clock after the strobe. Idle-line tests hold the line high for 12 bit periods, so the 10-bit threshold has clearly passed. Back-to-back tests keep gaps well under a bit period.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_ADDR, ST_STOP1, ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [7:0] data;
    logic       fe;
    logic       pe;
    logic       brk;
    logic       is_addr;
  } rx_char_t;
endpackage

// File: rtl/rxu_deglitch.sv
module rxu_deglitch #(
  parameter int DEGLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(DEGLITCH_CYC + 1);

  logic          s0_q, s1_q, out_q, out_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    out_n = out_q;
    cnt_n = cnt_q;
    if (s1_q == out_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(DEGLITCH_CYC - 1)) begin
      out_n = s1_q;
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= 1'b1;
      s1_q  <= 1'b1;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s0_q  <= din;
      s1_q  <= s0_q;
      out_q <= out_n;
      cnt_q <= cnt_n;
    end
  end

  assign dout = out_q;

  // R12: the filtered line only moves to a level the synchronizer already held
  assert_filter_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(s1_q) == out_q));
endmodule

// File: rtl/rxu_framer.sv
module rxu_framer
  import rxu_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int IDLE_BITS  = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     tick,
  input  logic     line,
  input  logic     len8,
  input  logic     par_en,
  input  logic     par_even,
  input  logic     two_stop,
  input  logic     addr_mode,
  output logic     done,
  output rx_char_t chr
);
  localparam int HALF       = OVERSAMPLE / 2;
  localparam int TW         = $clog2(OVERSAMPLE);
  localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE + 1;
  localparam int IW         = $clog2(IDLE_TICKS + 1);

  rx_state_t     state_q, state_n;
  logic [TW-1:0] tcnt_q, tcnt_n;
  logic [2:0]    bcnt_q, bcnt_n;
  logic [7:0]    sh_q, sh_n;
  logic          par_q, par_n, adr_q, adr_n, zero_q, zero_n, fe_q, fe_n;
  logic [IW-1:0] icnt_q, icnt_n;
  logic          iseen_q, iseen_n, line_q;
  logic          finish, fe_fin, zero_fin, done_q;
  rx_char_t      chr_q, chr_n;

  always_comb begin
    state_n = state_q; tcnt_n = tcnt_q; bcnt_n = bcnt_q; sh_n = sh_q;
    par_n = par_q; adr_n = adr_q; zero_n = zero_q; fe_n = fe_q;
    icnt_n = icnt_q; iseen_n = iseen_q;
    finish = 1'b0; fe_fin = fe_q; zero_fin = zero_q;
    case (state_q)
      ST_IDLE: begin
        tcnt_n = '0;
        if (line_q && !line) begin
          state_n = ST_START; bcnt_n = '0; zero_n = 1'b1;
          fe_n = 1'b0; par_n = 1'b0; adr_n = 1'b0;
        end
      end
      ST_START: if (tick) begin
        if (tcnt_q == TW'(HALF - 1)) begin
          tcnt_n  = '0;
          state_n = line ? ST_IDLE : ST_DATA;
        end else tcnt_n = tcnt_q + 1'b1;
      end
      default: if (tick) begin
        if (tcnt_q != TW'(OVERSAMPLE - 1)) tcnt_n = tcnt_q + 1'b1;
        else begin
          tcnt_n = '0;
          case (state_q)
            ST_DATA: begin
              sh_n   = {line, sh_q[7:1]};
              zero_n = zero_q & ~line;
              if (bcnt_q == (len8 ? 3'd7 : 3'd6)) begin
                bcnt_n  = '0;
                state_n = par_en ? ST_PAR : (addr_mode ? ST_ADDR : ST_STOP1);
              end else bcnt_n = bcnt_q + 1'b1;
            end
            ST_PAR: begin
              par_n = line; zero_n = zero_q & ~line;
              state_n = addr_mode ? ST_ADDR : ST_STOP1;
            end
            ST_ADDR: begin
              adr_n = line; zero_n = zero_q & ~line; state_n = ST_STOP1;
            end
            ST_STOP1: begin
              fe_fin = ~line; zero_fin = zero_q & ~line;
              fe_n = fe_fin; zero_n = zero_fin;
              if (two_stop) state_n = ST_STOP2;
              else begin finish = 1'b1; state_n = ST_IDLE; end
            end
            ST_STOP2: begin
              fe_fin = fe_q | ~line; fe_n = fe_fin;
              finish = 1'b1; state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
          endcase
        end
      end
    endcase

    if (state_q != ST_IDLE || !line) icnt_n = '0;
    else if (tick && icnt_q != IW'(IDLE_TICKS)) icnt_n = icnt_q + 1'b1;
    if (icnt_q == IW'(IDLE_TICKS)) iseen_n = 1'b1;
    if (finish) iseen_n = 1'b0;

    chr_n.data    = len8 ? sh_q : {1'b0, sh_q[7:1]};
    chr_n.fe      = fe_fin;
    chr_n.pe      = par_en && (par_q != ((^chr_n.data) ^ ~par_even));
    chr_n.brk     = zero_fin;
    chr_n.is_addr = addr_mode ? adr_q : iseen_q;

    if (soft_rst) begin
      state_n = ST_IDLE; tcnt_n = '0; icnt_n = '0; iseen_n = 1'b0; finish = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; tcnt_q <= '0; bcnt_q <= '0; sh_q <= '0;
      par_q <= 1'b0; adr_q <= 1'b0; zero_q <= 1'b0; fe_q <= 1'b0;
      icnt_q <= '0; iseen_q <= 1'b0; line_q <= 1'b1; done_q <= 1'b0;
      chr_q <= '0;
    end else begin
      state_q <= state_n; tcnt_q <= tcnt_n; bcnt_q <= bcnt_n; sh_q <= sh_n;
      par_q <= par_n; adr_q <= adr_n; zero_q <= zero_n; fe_q <= fe_n;
      icnt_q <= icnt_n; iseen_q <= iseen_n; line_q <= line; done_q <= finish;
      if (finish) chr_q <= chr_n;
    end
  end

  assign done = done_q;
  assign chr  = chr_q;

  // R12: a start bit high at its midpoint sends the receiver back to idle
  assert_false_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && tcnt_q == TW'(HALF - 1) && line)
    |=> (state_q == ST_IDLE && !done_q));
  // R2: 7-bit characters never carry a set top bit
  assert_seven_bit_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !len8) |=> !chr_q.data[7]);
  // R13: no character completes while soft reset is held
  assert_soft_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !done_q);
endmodule

// File: rtl/rxu_holdbuf.sv
module rxu_holdbuf
  import rxu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       done,
  input  rx_char_t   chr,
  input  logic       wake_only,
  input  logic       keep_err,
  input  logic       rd,
  output logic [7:0] data,
  output logic       ready,
  output logic       is_addr,
  output logic       fe,
  output logic       pe,
  output logic       oe,
  output logic       brk
);
  logic [7:0] data_q, data_n;
  logic       rdy_q, rdy_n, adr_q, adr_n, fe_q, fe_n, pe_q, pe_n;
  logic       oe_q, oe_n, brk_q, brk_n, has_err, accept;

  assign has_err = chr.fe | chr.pe | chr.brk;
  assign accept  = done && (keep_err || !has_err) && (!wake_only || chr.is_addr);

  always_comb begin
    data_n = data_q; rdy_n = rdy_q; adr_n = adr_q;
    fe_n = fe_q; pe_n = pe_q; oe_n = oe_q; brk_n = brk_q;
    if (rd) begin
      rdy_n = 1'b0; adr_n = 1'b0; fe_n = 1'b0;
      pe_n = 1'b0; oe_n = 1'b0; brk_n = 1'b0;
    end
    if (accept) begin
      data_n = chr.data;
      rdy_n  = 1'b1;
      adr_n  = chr.is_addr;
      fe_n   = fe_n | chr.fe;
      pe_n   = pe_n | chr.pe;
      brk_n  = brk_n | chr.brk;
      if (rdy_q && !rd) oe_n = 1'b1;
    end
    if (soft_rst) begin
      rdy_n = 1'b0; adr_n = 1'b0; fe_n = 1'b0;
      pe_n = 1'b0; oe_n = 1'b0; brk_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; rdy_q <= 1'b0; adr_q <= 1'b0; fe_q <= 1'b0;
      pe_q <= 1'b0; oe_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      data_q <= data_n; rdy_q <= rdy_n; adr_q <= adr_n; fe_q <= fe_n;
      pe_q <= pe_n; oe_q <= oe_n; brk_q <= brk_n;
    end
  end

  assign data = data_q; assign ready = rdy_q; assign is_addr = adr_q;
  assign fe = fe_q; assign pe = pe_q; assign oe = oe_q; assign brk = brk_q;

  // R11: a read with no new character leaves every flag clear
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done && !soft_rst) |=> (!rdy_q && !adr_q && !fe_q && !pe_q && !oe_q && !brk_q));
  // R6: a delivery onto an unread character flags overrun
  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rdy_q && !rd && !soft_rst) |=> oe_q);
  // R10: a rejected erroneous character leaves the ready flag unchanged
  assert_reject_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !keep_err && has_err && !rd && !soft_rst) |=> (rdy_q == $past(rdy_q)));
  // R13: soft reset clears the status
  assert_soft_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rdy_q && !oe_q && !fe_q && !pe_q && !brk_q));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import rxu_pkg::*;
#(
  parameter int OVERSAMPLE   = 16,
  parameter int DEGLITCH_CYC = 4,
  parameter int IDLE_BITS    = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       os_tick,
  input  logic       rx_serial,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_two_stop,
  input  logic       cfg_addr_bit_mode,
  input  logic       cfg_wake_filter,
  input  logic       cfg_keep_err,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       rx_is_addr,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_break,
  output logic       err_any
);
  logic     line_f, chr_done;
  rx_char_t chr;

  rxu_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(rx_serial), .dout(line_f)
  );

  rxu_framer #(.OVERSAMPLE(OVERSAMPLE), .IDLE_BITS(IDLE_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(os_tick), .line(line_f),
    .len8(cfg_len8), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .two_stop(cfg_two_stop), .addr_mode(cfg_addr_bit_mode),
    .done(chr_done), .chr(chr)
  );

  rxu_holdbuf u_buf (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .done(chr_done), .chr(chr),
    .wake_only(cfg_wake_filter), .keep_err(cfg_keep_err), .rd(rd_strobe),
    .data(rx_data), .ready(rx_ready), .is_addr(rx_is_addr),
    .fe(err_frame), .pe(err_parity), .oe(err_overrun), .brk(err_break)
  );

  assign err_any = err_frame | err_parity | err_overrun | err_break;
endmodule

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  localparam int BIT = 32;  // 16 ticks per bit, one tick every 2 clocks

  logic clk, rst_n, soft_rst, os_tick, rx_serial;
  logic cfg_len8, cfg_par_en, cfg_par_even, cfg_two_stop;
  logic cfg_addr_bit_mode, cfg_wake_filter, cfg_keep_err, rd_strobe;
  logic [7:0] rx_data;
  logic rx_ready, rx_is_addr, err_frame, err_parity, err_overrun, err_break, err_any;
  int n_run, n_fail;

  mp_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .os_tick(os_tick),
    .rx_serial(rx_serial), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .cfg_addr_bit_mode(cfg_addr_bit_mode), .cfg_wake_filter(cfg_wake_filter),
    .cfg_keep_err(cfg_keep_err), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_is_addr(rx_is_addr),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .err_break(err_break), .err_any(err_any)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) os_tick <= 1'b0; else os_tick <= ~os_tick;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int cycles);
    rx_serial = v;
    repeat (cycles) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [7:0] d);
    logic [7:0] m;
    m = cfg_len8 ? d : {1'b0, d[6:0]};
    return (^m) ^ ~cfg_par_even;
  endfunction

  task automatic send(input logic [7:0] d, input logic pbit, input logic abit,
                      input logic s1, input logic s2);
    hold(1'b0, BIT);
    for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) hold(d[i], BIT);
    if (cfg_par_en) hold(pbit, BIT);
    if (cfg_addr_bit_mode) hold(abit, BIT);
    hold(s1, BIT);
    if (cfg_two_stop) hold(s2, BIT);
    rx_serial = 1'b1;
  endtask

  task automatic do_read();
    rd_strobe = 1'b1; @(negedge clk);
    rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset ready", rx_ready, 0);
    chk("R11 reset flags", {rx_is_addr, err_any, rx_data}, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 data", rx_data, 8'hA5);
    chk("R1 ready", rx_ready, 1);
    chk("R11 err_any clean", err_any, 0);
    do_read();
    chk("R11 read clears ready", rx_ready, 0);
  endtask

  task automatic t_parity();
    cfg_len8 = 0; cfg_par_en = 1; cfg_par_even = 1;
    send(8'hD5, good_par(8'h55), 1'b0, 1'b1, 1'b1);
    chk("R2 7-bit justified", rx_data, 8'h55);
    chk("R3 even ok", err_parity, 0);
    do_read();
    cfg_par_even = 0;
    send(8'h55, ~good_par(8'h55), 1'b0, 1'b1, 1'b1);
    chk("R3 odd mismatch", err_parity, 1);
    chk("R11 err_any parity", err_any, 1);
    do_read();
    chk("R11 read clears parity", err_parity, 0);
    cfg_keep_err = 0;
    send(8'h55, ~good_par(8'h55), 1'b0, 1'b1, 1'b1);
    chk("R10 bad char rejected", {rx_ready, err_parity}, 0);
    cfg_keep_err = 1; cfg_len8 = 1; cfg_par_en = 0;
    send(8'h81, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R3 parity disabled data", rx_data, 8'h81);
    chk("R3 parity disabled flag", err_parity, 0);
    do_read();
  endtask

  task automatic t_stop();
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    hold(1'b1, BIT);
    chk("R4 stop low frame", {err_frame, err_break, rx_ready}, 3'b101);
    do_read();
    cfg_two_stop = 1;
    send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0);
    hold(1'b1, BIT);
    chk("R4 second stop low", err_frame, 1);
    do_read();
    send(8'h3D, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 two good stops", {err_frame, rx_data}, {1'b0, 8'h3D});
    do_read();
    cfg_two_stop = 0;
  endtask

  task automatic t_break();
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    hold(1'b1, BIT);
    chk("R5 break", {err_break, err_frame}, 2'b11);
    do_read();
    cfg_keep_err = 0;
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    hold(1'b1, BIT);
    chk("R10 break rejected", {rx_ready, err_break}, 0);
    cfg_keep_err = 1;
  endtask

  task automatic t_overrun();
    send(8'h11, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 no overrun first", err_overrun, 0);
    send(8'h22, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 overrun", err_overrun, 1);
    chk("R6 newer kept", rx_data, 8'h22);
    do_read();
    chk("R11 overrun cleared", err_overrun, 0);
  endtask

  task automatic t_addr_bit();
    cfg_addr_bit_mode = 1; cfg_wake_filter = 1;
    send(8'h40, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 data filtered", rx_ready, 0);
    send(8'h41, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7 address accepted", {rx_ready, rx_is_addr, rx_data}, {2'b11, 8'h41});
    do_read();
    cfg_wake_filter = 0;
    send(8'h42, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 data marked", {rx_ready, rx_is_addr}, 2'b10);
    do_read();
    cfg_addr_bit_mode = 0;
  endtask

  task automatic t_idle_line();
    hold(1'b1, 12 * BIT);
    send(8'h10, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 first after idle is address", rx_is_addr, 1);
    do_read();
    send(8'h20, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 follow-on is data", {rx_ready, rx_is_addr}, 2'b10);
    do_read();
    cfg_wake_filter = 1;
    hold(1'b1, 12 * BIT);
    send(8'h30, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 idle address delivered", {rx_ready, rx_data}, {1'b1, 8'h30});
    do_read();
    send(8'h31, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R9 idle data filtered", {rx_ready, rx_data}, {1'b0, 8'h30});
    cfg_wake_filter = 0;
  endtask

  task automatic t_glitch();
    hold(1'b0, 2); hold(1'b1, 2 * BIT);
    chk("R12 short pulse ignored", rx_ready, 0);
    hold(1'b0, 12); hold(1'b1, 2 * BIT);
    chk("R12 false start aborted", rx_ready, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R12 receives after abort", {rx_ready, rx_data}, {1'b1, 8'h5A});
    do_read();
  endtask

  task automatic t_soft();
    send(8'h66, 1'b0, 1'b0, 1'b0, 1'b1);
    hold(1'b1, BIT);
    soft_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 flags cleared", {rx_ready, err_any}, 0);
    send(8'h67, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 held idle", rx_ready, 0);
    soft_rst = 1'b0;
    hold(1'b1, BIT);
    send(8'h77, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 released", {rx_ready, rx_data}, {1'b1, 8'h77});
    do_read();
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; soft_rst = 1'b0; rx_serial = 1'b1; rd_strobe = 1'b0;
    cfg_len8 = 1; cfg_par_en = 0; cfg_par_even = 1; cfg_two_stop = 0;
    cfg_addr_bit_mode = 0; cfg_wake_filter = 0; cfg_keep_err = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_stop();
    t_break();
    t_overrun();
    t_addr_bit();
    t_idle_line();
    t_glitch();
    t_soft();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule